// File: doc/BRIEF.md
# Address Region Access Protection Unit

This block stands between bus masters and a slave address space and screens one single-beat read or write request at a time. Each request carries an address, a 4-bit master index, a direction and a non-secure flag. The unit compares it against up to sixteen programmable address windows. Each window has inclusive bounds, a mask of permitted masters, separate read and write permissions, an enable and a secure marking. An address that falls in no enabled window is judged by two default permission bits instead.

A request that passes goes to the slave port, and the slave's reply is returned to the requester. A request that breaks the rules is poisoned when the matching poison enable is set. A poisoned request never reaches the slave. It is answered one cycle after acceptance with a selectable error code and zero read data.

A write-only configuration port programs the windows, the control word, a lock bit and a set of bypass masters. Once the lock is set, only bypass masters can still change the configuration.

The controller is a three-state machine:
- `ST_IDLE` is the only state that accepts a request.
- `ST_IDLE -> ST_FWD` on an accepted clean request.
- `ST_IDLE -> ST_ERR` on an accepted poisoned request.
- `ST_FWD -> ST_IDLE` when the slave acknowledges.
- `ST_ERR -> ST_IDLE` unconditionally after one cycle.

Top module: `region_guard`

## Requirements
- R1: Window k sits at configuration word 16+4k. The words are: +0 low bound, +1 high bound, +2 master mask, +3 attributes. The attribute bits are bit0 write-ok, bit1 read-ok, bit2 enable, bit3 secure. A window claims an address when it is enabled and low <= address <= high, with both bounds inclusive. A disabled window never claims.
- R2: In the claiming window, bit `req_mid` of the master mask must be set. Otherwise the access is a violation.
- R3: In the claiming window, a write needs write-ok and a read needs read-ok. Otherwise the access is a violation.
- R4: When several enabled windows claim an address, the lowest-numbered one alone decides the result.
- R5: The control word is at configuration word 0. For an address claimed by no window, bit0 allows reads and bit1 allows writes. A cleared bit makes the access a violation.
- R6: With control bit2 set, a violation is poisoned. With bit2 clear, a violation is forwarded to the slave.
- R7: With control bit3 set, a request with `req_nonsec`=1 to a claiming window that has secure=1 is poisoned.
- R8: A poisoned request never drives `slv_valid`. It answers with `rsp_valid` one cycle after acceptance, with `rsp_rdata`=0. Its `rsp_code` is 2'b11 when control bit4 was 1 at acceptance and 2'b10 otherwise.
- R9: A forwarded request drives `slv_valid` until `slv_ack`. `rsp_valid` rises in the acknowledge cycle with code 2'b00. `rsp_rdata` carries `slv_rdata` for reads and is 0 for writes. `req_ready` is low until the request completes.
- R10: Writing 1 to bit0 of configuration word 1 sets the lock, which stays set until reset. While locked, configuration writes from masters outside the bypass mask are ignored.
- R11: The bypass mask is at configuration word 2, bit i for master i. While locked, writes from bypass masters still take effect.
- R12: Reset has these effects:
  - every window is disabled;
  - the control word and the lock are cleared;
  - `req_ready`=1;
  - `rsp_valid`=0 and `slv_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (7) | Configuration word index |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_mid | input | MID_W | Master issuing the configuration write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_mid | input | MID_W | Requesting master index |
| req_nonsec | input | 1 | Request is non-secure |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 00 OK, 10 slave error, 11 decode error |
| rsp_rdata | output | DATA_W | Read data |
| slv_valid | output | 1 | Forwarded request to the slave |
| slv_write | output | 1 | Forwarded direction |
| slv_addr | output | ADDR_W | Forwarded address |
| slv_wdata | output | DATA_W | Forwarded write data |
| slv_ack | input | 1 | Slave completes the forwarded request |
| slv_rdata | input | DATA_W | Slave read data |

## Verification
The hardest case to reach from the ports is an address claimed by two overlapping windows where the lower window refuses and the higher one would grant. A second hard case is an attempted reconfiguration after the lock, which only shows up in later request outcomes.

The stimulus programs overlapping windows, with a narrow one at a lower index inside a wide read-only one. It then walks a table of requests across both windows' bounds, masters and directions. After setting the lock, it attempts writes from a plain master and from a bypass master. The effect of each attempt is judged by replaying requests whose verdict depends on the changed control bits.

// File: rtl/rgd_pkg.sv
package rgd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FWD,
        ST_ERR
    } rgd_state_e;

    localparam logic [1:0] RSP_OKAY   = 2'b00;
    localparam logic [1:0] RSP_SLVERR = 2'b10;
    localparam logic [1:0] RSP_DECERR = 2'b11;

    // control word, bit0 at the bottom
    typedef struct packed {
        logic err_decerr;
        logic psn_attr;
        logic psn_addr;
        logic def_wr;
        logic def_rd;
    } rgd_ctrl_t;

    // window attributes, bit0 at the bottom
    typedef struct packed {
        logic secure;
        logic enable;
        logic rd_ok;
        logic wr_ok;
    } rgd_attr_t;

    localparam int CTRL_W   = $bits(rgd_ctrl_t);
    localparam int ATTR_W   = $bits(rgd_attr_t);
    localparam int WIN_BASE = 16;

endpackage

// File: rtl/rgd_regfile.sv
module rgd_regfile
    import rgd_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int MID_W       = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CFG_AW      = 7
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cfg_we,
    input  logic [CFG_AW-1:0]                        cfg_addr,
    input  logic [DATA_W-1:0]                        cfg_wdata,
    input  logic [MID_W-1:0]                         cfg_mid,
    output rgd_ctrl_t                                ctrl,
    output logic                                     locked,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]       win_lo,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]       win_hi,
    output logic [NUM_REGIONS-1:0][(1<<MID_W)-1:0]   win_mask,
    output rgd_attr_t [NUM_REGIONS-1:0]              win_attr
);
    localparam int NUM_MIDS = 1 << MID_W;

    logic [NUM_MIDS-1:0] bypass_q;
    logic                wr_take;

    // a locked file still accepts writes from bypass masters
    assign wr_take = cfg_we && (!locked || bypass_q[cfg_mid]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl     <= '0;
            locked   <= 1'b0;
            bypass_q <= '0;
            win_lo   <= '0;
            win_hi   <= '0;
            win_mask <= '0;
            win_attr <= '0;
        end else if (wr_take) begin
            if (cfg_addr == CFG_AW'(0)) ctrl     <= cfg_wdata[CTRL_W-1:0];
            if (cfg_addr == CFG_AW'(1)) locked   <= locked | cfg_wdata[0];
            if (cfg_addr == CFG_AW'(2)) bypass_q <= cfg_wdata[NUM_MIDS-1:0];
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (cfg_addr == CFG_AW'(WIN_BASE + 4*r + 0)) win_lo[r]   <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == CFG_AW'(WIN_BASE + 4*r + 1)) win_hi[r]   <= cfg_wdata[ADDR_W-1:0];
                if (cfg_addr == CFG_AW'(WIN_BASE + 4*r + 2)) win_mask[r] <= cfg_wdata[NUM_MIDS-1:0];
                if (cfg_addr == CFG_AW'(WIN_BASE + 4*r + 3)) win_attr[r] <= cfg_wdata[ATTR_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rgd_match.sv
module rgd_match
    import rgd_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int MID_W       = 4,
    parameter int ADDR_W      = 32
) (
    input  rgd_ctrl_t                                ctrl,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]       win_lo,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]       win_hi,
    input  logic [NUM_REGIONS-1:0][(1<<MID_W)-1:0]   win_mask,
    input  rgd_attr_t [NUM_REGIONS-1:0]              win_attr,
    input  logic [ADDR_W-1:0]                        addr,
    input  logic [MID_W-1:0]                         mid,
    input  logic                                     write,
    input  logic                                     nonsec,
    output logic                                     poison
);
    localparam int SEL_W = $clog2(NUM_REGIONS > 1 ? NUM_REGIONS : 2);

    logic [NUM_REGIONS-1:0] claim;
    logic [SEL_W-1:0]       sel;
    logic                   any;
    logic                   violation;
    logic                   attr_bad;
    rgd_attr_t              a;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
        assign claim[r] = win_attr[r].enable && (addr >= win_lo[r]) && (addr <= win_hi[r]);
    end

    // lowest index wins: scan from the top so the last hit kept is the lowest
    always_comb begin
        sel = '0;
        any = 1'b0;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (claim[r]) begin
                sel = SEL_W'(r);
                any = 1'b1;
            end
        end
    end

    always_comb begin
        a = win_attr[sel];
        if (any) begin
            violation = !win_mask[sel][mid] || !(write ? a.wr_ok : a.rd_ok);
        end else begin
            violation = !(write ? ctrl.def_wr : ctrl.def_rd);
        end
        attr_bad = any && a.secure && nonsec;
        poison   = (violation && ctrl.psn_addr) || (attr_bad && ctrl.psn_attr);
    end

endmodule

// File: rtl/region_guard.sv
module region_guard
    import rgd_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int MID_W       = 4,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CFG_AW      = $clog2(WIN_BASE + 4*NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [MID_W-1:0]  cfg_mid,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [MID_W-1:0]  req_mid,
    input  logic              req_nonsec,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [1:0]        rsp_code,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              slv_valid,
    output logic              slv_write,
    output logic [ADDR_W-1:0] slv_addr,
    output logic [DATA_W-1:0] slv_wdata,
    input  logic              slv_ack,
    input  logic [DATA_W-1:0] slv_rdata
);
    localparam int NUM_MIDS = 1 << MID_W;

    rgd_ctrl_t                             ctrl;
    logic                                  cfg_locked;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]    win_lo;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]    win_hi;
    logic [NUM_REGIONS-1:0][NUM_MIDS-1:0]  win_mask;
    rgd_attr_t [NUM_REGIONS-1:0]           win_attr;
    logic                                  poison;

    rgd_state_e        state_q, state_d;
    logic              accept;
    logic              cap_write;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic [1:0]        cap_err;

    rgd_regfile #(
        .NUM_REGIONS(NUM_REGIONS), .MID_W(MID_W), .ADDR_W(ADDR_W),
        .DATA_W(DATA_W), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_mid(cfg_mid), .ctrl(ctrl),
        .locked(cfg_locked), .win_lo(win_lo), .win_hi(win_hi),
        .win_mask(win_mask), .win_attr(win_attr)
    );

    rgd_match #(
        .NUM_REGIONS(NUM_REGIONS), .MID_W(MID_W), .ADDR_W(ADDR_W)
    ) u_match (
        .ctrl(ctrl), .win_lo(win_lo), .win_hi(win_hi), .win_mask(win_mask),
        .win_attr(win_attr), .addr(req_addr), .mid(req_mid),
        .write(req_write), .nonsec(req_nonsec), .poison(poison)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cap_write <= 1'b0;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_err   <= RSP_SLVERR;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cap_write <= req_write;
                cap_addr  <= req_addr;
                cap_wdata <= req_wdata;
                cap_err   <= ctrl.err_decerr ? RSP_DECERR : RSP_SLVERR;
            end
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept) state_d = poison ? ST_ERR : ST_FWD;
            ST_FWD:  if (slv_ack) state_d = ST_IDLE;
            ST_ERR:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_code  = RSP_OKAY;
        rsp_rdata = '0;
        slv_valid = 1'b0;
        slv_write = cap_write;
        slv_addr  = cap_addr;
        slv_wdata = cap_wdata;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_FWD: begin
                slv_valid = 1'b1;
                rsp_valid = slv_ack;
                if (slv_ack && !cap_write) rsp_rdata = slv_rdata;
            end
            ST_ERR: begin
                rsp_valid = 1'b1;
                rsp_code  = cap_err;
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              slv_valid,
    input logic              slv_ack,
    input logic [ADDR_W-1:0] slv_addr,
    input logic              cfg_locked
);
    AST_ERR_NOT_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> !slv_valid); // R8

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'b00) |-> (rsp_rdata == '0)); // R8

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !slv_valid) |-> $past(req_valid && req_ready)); // R8

    AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!slv_valid && !rsp_valid)); // R9

    AST_FWD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_valid && !slv_ack) |=> (slv_valid && $stable(slv_addr))); // R9

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked); // R10

endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .slv_valid(slv_valid), .slv_ack(slv_ack), .slv_addr(slv_addr),
    .cfg_locked(cfg_locked)
);

// File: tb/region_guard_tb.sv
module region_guard_tb;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [3:0]    cfg_mid = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [3:0]    req_mid = '0;
    logic          req_nonsec = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_code;
    logic [DW-1:0] rsp_rdata;
    logic          slv_valid, slv_write;
    logic [AW-1:0] slv_addr;
    logic [DW-1:0] slv_wdata;
    logic          slv_ack;
    logic [DW-1:0] slv_rdata;
    logic          slv_stall = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // slave model: answers in the same cycle unless stalled
    assign slv_ack   = slv_valid && !slv_stall;
    assign slv_rdata = slv_addr ^ 32'hA5A5_0000;

    region_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_mid(cfg_mid), .req_valid(req_valid),
        .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
        .req_mid(req_mid), .req_nonsec(req_nonsec), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .slv_valid(slv_valid), .slv_write(slv_write), .slv_addr(slv_addr),
        .slv_wdata(slv_wdata), .slv_ack(slv_ack), .slv_rdata(slv_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [3:0]  mid;
        logic        ns;
        logic        poison;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 32'h0000_1000, 4'd0, 1'b0, 1'b0},  // R1 low bound inclusive
        '{1'b1, 32'h0000_13FF, 4'd5, 1'b0, 1'b0},  // R1 high bound inclusive
        '{1'b0, 32'h0000_13FF, 4'd3, 1'b0, 1'b1},  // R4 window0 refuses mid3, window2 ignored
        '{1'b0, 32'h0000_1400, 4'd3, 1'b0, 1'b0},  // R3 window2 read ok
        '{1'b1, 32'h0000_1400, 4'd3, 1'b0, 1'b1},  // R3 window2 write denied
        '{1'b0, 32'h0000_1C00, 4'd2, 1'b0, 1'b0},  // R2 mid2 allowed in window1
        '{1'b0, 32'h0000_1C00, 4'd3, 1'b0, 1'b1},  // R2 mid3 not in window1 mask
        '{1'b0, 32'h0000_1C00, 4'd2, 1'b1, 1'b1},  // R7 non-secure to secure window
        '{1'b0, 32'h0000_3000, 4'd7, 1'b0, 1'b0},  // R1 disabled window3, R5 default read
        '{1'b1, 32'h0000_3000, 4'd7, 1'b0, 1'b1},  // R5 default write denied
        '{1'b0, 32'h0000_0FFF, 4'd0, 1'b0, 1'b0},  // R5 below all windows
        '{1'b1, 32'h0000_1FFF, 4'd2, 1'b0, 1'b0}   // R1 window1 high bound
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [6:0] a, input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_mid = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // issue one request and check the response seen in the next cycle
    task automatic do_req(input string req, input logic wr, input logic [31:0] a,
                          input logic [3:0] m, input logic ns, input logic psn,
                          input logic [1:0] err);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mid = m;
        req_nonsec = ns; req_wdata = ~a;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({req, " rsp_code"}, 32'(rsp_code), psn ? 32'(err) : 32'd0);
        check({req, " rsp_rdata"}, rsp_rdata, (psn || wr) ? 32'd0 : (a ^ 32'hA5A5_0000));
        check({req, " slv_valid"}, 32'(slv_valid), psn ? 32'd0 : 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 req_ready", 32'(req_ready), 32'd1);
        check("R12 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R12 slv_valid", 32'(slv_valid), 32'd0);
        rst_n = 1'b1;

        cfg_wr(7'd2, 32'h0000_0200, 4'd3);          // bypass master 9
        cfg_wr(7'd16, 32'h1000, 4'd3); cfg_wr(7'd17, 32'h13FF, 4'd3);
        cfg_wr(7'd18, 32'h0021, 4'd3); cfg_wr(7'd19, 32'h7, 4'd3);
        cfg_wr(7'd20, 32'h1C00, 4'd3); cfg_wr(7'd21, 32'h1FFF, 4'd3);
        cfg_wr(7'd22, 32'h0004, 4'd3); cfg_wr(7'd23, 32'hF, 4'd3);
        cfg_wr(7'd24, 32'h1000, 4'd3); cfg_wr(7'd25, 32'h1FFF, 4'd3);
        cfg_wr(7'd26, 32'hFFFF, 4'd3); cfg_wr(7'd27, 32'h6, 4'd3);
        cfg_wr(7'd28, 32'h3000, 4'd3); cfg_wr(7'd29, 32'h30FF, 4'd3);
        cfg_wr(7'd30, 32'hFFFF, 4'd3); cfg_wr(7'd31, 32'h3, 4'd3);
        cfg_wr(7'd0, 32'h1D, 4'd3);                 // def_rd, psn_addr, psn_attr, decerr

        for (int i = 0; i < NV; i++) begin
            do_req($sformatf("vec%0d R8/R9", i), VECS[i].wr, VECS[i].addr,
                   VECS[i].mid, VECS[i].ns, VECS[i].poison, 2'b11);
        end

        // R8 slave-error selection
        cfg_wr(7'd0, 32'h0D, 4'd3);
        do_req("R8 slverr", 1'b1, 32'h1400, 4'd3, 1'b0, 1'b1, 2'b10);
        // R6 violation forwarded with address poisoning off
        cfg_wr(7'd0, 32'h09, 4'd3);
        do_req("R6 psn_addr off", 1'b1, 32'h1400, 4'd3, 1'b0, 1'b0, 2'b10);
        do_req("R7 attr still on", 1'b0, 32'h1C00, 4'd2, 1'b1, 1'b1, 2'b10);
        // R7 attribute poisoning off
        cfg_wr(7'd0, 32'h05, 4'd3);
        do_req("R7 psn_attr off", 1'b0, 32'h1C00, 4'd2, 1'b1, 1'b0, 2'b10);

        // R9 stalled slave
        @(negedge clk);
        slv_stall = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h1000; req_mid = 4'd0; req_nonsec = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 stall slv_valid", 32'(slv_valid), 32'd1);
        check("R9 stall rsp_valid", 32'(rsp_valid), 32'd0);
        check("R9 stall req_ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R9 stall held", 32'(slv_valid), 32'd1);
        slv_stall = 1'b0;
        #1;
        check("R9 ack rsp_valid", 32'(rsp_valid), 32'd1);
        check("R9 ack rdata", rsp_rdata, 32'h1000 ^ 32'hA5A5_0000);

        // R10 lock and blocked writes (ctrl now 0x05: def_rd on, def_wr off)
        cfg_wr(7'd1, 32'h1, 4'd3);
        cfg_wr(7'd0, 32'h04, 4'd3);                 // would clear def_rd
        cfg_wr(7'd31, 32'h7, 4'd3);                 // would enable window3
        do_req("R10 ctrl write ignored", 1'b0, 32'h3000, 4'd7, 1'b0, 1'b0, 2'b10);
        do_req("R10 window write ignored", 1'b1, 32'h3000, 4'd7, 1'b0, 1'b1, 2'b10);
        // R11 bypass master writes
        cfg_wr(7'd0, 32'h04, 4'd9);
        do_req("R11 bypass ctrl write", 1'b0, 32'h3000, 4'd7, 1'b0, 1'b1, 2'b10);
        cfg_wr(7'd1, 32'h0, 4'd9);                  // lock stays set
        cfg_wr(7'd0, 32'h05, 4'd3);
        do_req("R10 lock sticky", 1'b0, 32'h3000, 4'd7, 1'b0, 1'b1, 2'b10);

        // R12 reset mid-run clears windows and lock
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 again req_ready", 32'(req_ready), 32'd1);
        check("R12 again slv_valid", 32'(slv_valid), 32'd0);
        rst_n = 1'b1;
        cfg_wr(7'd0, 32'h04, 4'd3);                 // accepted only if lock cleared
        do_req("R12 windows disabled", 1'b0, 32'h1000, 4'd0, 1'b0, 1'b1, 2'b10);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule